// File: doc/BRIEF.md
# Dual Gated Timer/Counter

This block holds two 16-bit timer/counters, each kept as a low byte and a high byte that software can read and write at any time. A shared configuration register gives every timer a two-bit mode, a source select (internal clock ticks or falling edges on an external count pin) and a gate enable. A control register holds one run bit and one overflow flag per timer. Flags are cleared by writing the control register or by a one-cycle acknowledge pulse from the interrupt controller.

Four modes are offered: a 13-bit counter whose low five bits act as a prescaler, a plain 16-bit counter, an 8-bit counter that reloads from the high byte, and a split mode in which timer 0 becomes two independent 8-bit counters. In split mode the upper half of timer 0 borrows the run bit and the flag of timer 1. The internal tick of each timer is either the system clock itself (high-speed select) or the system clock divided by 12 or by 4.

Register access is a plain single-cycle port: writes take effect at the clock edge where `reg_wr` is high, and `reg_rdata` shows the addressed register combinationally.

Top module: `tmr_pair`

## Requirements
- R1: After reset every register (addresses 0 to 7) reads 0 and both overflow flags are 0.
- R2: Register map: address 0 = configuration (timer 0 in bits 3:0, timer 1 in bits 7:4; within a nibble bits 1:0 mode, bit 2 source select, bit 3 gate enable), 1 = control (bit 0 run 0, bit 1 flag 0, bit 2 run 1, bit 3 flag 1, bits 7:4 read 0), 2/3 = timer 0 low/high, 4/5 = timer 1 low/high, 6 and 7 read 0; written values read back.
- R3: Mode 1 counts the 16-bit pair by one per enabled tick; a tick at FFFFh wraps it to 0000h and sets the flag.
- R4: Mode 0 counts a 13-bit value formed by the high byte above low-byte bits 4:0; low-byte bits 7:5 never change by counting; a tick at all-ones sets the flag.
- R5: Mode 2 increments the low byte only; a tick at FFh loads the high byte into the low byte and sets the flag.
- R6: With timer 0 in mode 3, its low byte counts under run 0, gate 0 and source 0 and sets flag 0 at FFh; its high byte counts timer 0 internal ticks while run 1 is set and sets flag 1 at FFh; timer 1 overflows then set no flag.
- R7: Timer 1 in mode 3 holds its count.
- R8: With gate enable set a timer counts only while its run bit is 1 and its gate pin is high; the gate pin level takes effect at the third rising edge after it changes.
- R9: With source select 1 a timer counts falling edges of its count pin; an edge is counted at the third rising edge after the pin falls.
- R10: Internal tick: every edge when the high-speed select is 1; otherwise every 4th (divide select 1) or 12th (divide select 0) rising edge counted from reset release.
- R11: A flag is cleared by an acknowledge pulse or by writing 0 to it; an overflow in the same cycle wins over both.
- R12: A write to a count byte wins over counting in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fast_sel | input | 2 | Per timer: tick on every system clock |
| div4_sel | input | 2 | Per timer: internal divider 4 (1) or 12 (0) |
| count_pin | input | 2 | External count inputs, falling edge counted |
| gate_pin | input | 2 | External gate inputs |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| irq_ack | input | 2 | Per timer flag clear pulse |
| ovf_flag | output | 2 | Overflow flags |

## Verification
A wrong count or a wrong reload shows up at the next read of the affected count byte, within one tick of the fault. Broken prescaling or synchronizer depth moves every later count and overflow in time, so the flags diverge from the bench model within one tick period. A wrong flag priority shows at `ovf_flag` on the cycle after the colliding acknowledge and overflow.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CFG_W = 4;

  typedef enum logic [1:0] {
    MODE_13B    = 2'd0,
    MODE_16B    = 2'd1,
    MODE_RELOAD = 2'd2,
    MODE_SPLIT  = 2'd3
  } tmr_mode_e;

  typedef struct packed {
    logic      gate;
    logic      ext_sel;
    tmr_mode_e mode;
  } tmr_cfg_t;

  localparam logic [2:0] ADDR_CFG  = 3'd0;
  localparam logic [2:0] ADDR_CTRL = 3'd1;
  localparam logic [2:0] ADDR_T0L  = 3'd2;
  localparam logic [2:0] ADDR_T0H  = 3'd3;
  localparam logic [2:0] ADDR_T1L  = 3'd4;
  localparam logic [2:0] ADDR_T1H  = 3'd5;
  localparam int NUM_REGS = 6;
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o
);
  logic [STAGES-1:0] shift_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shift_q <= '0;
        else        shift_q <= pin_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shift_q <= '0;
        else        shift_q <= {shift_q[STAGES-2:0], pin_i};
      end
    end
  endgenerate

  assign level_o = shift_q[STAGES-1];
endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int SLOW_DIV = 12,
  parameter int FAST_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_slow_o,
  output logic tick_fast_o
);
  localparam int S_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam int F_W = (FAST_DIV > 1) ? $clog2(FAST_DIV) : 1;
  localparam logic [S_W-1:0] S_LAST = S_W'(SLOW_DIV - 1);
  localparam logic [F_W-1:0] F_LAST = F_W'(FAST_DIV - 1);

  logic [S_W-1:0] slow_q;
  logic [F_W-1:0] fast_q;

  assign tick_slow_o = (slow_q == S_LAST);
  assign tick_fast_o = (fast_q == F_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slow_q <= '0;
      fast_q <= '0;
    end else begin
      slow_q <= tick_slow_o ? '0 : slow_q + S_W'(1);
      fast_q <= tick_fast_o ? '0 : fast_q + F_W'(1);
    end
  end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int PRE_W    = 5,
  parameter bit SPLIT_OK = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tmr_mode_e         mode_i,
  input  logic              en_i,
  input  logic              en_hi_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] lo_o,
  output logic [BYTE_W-1:0] hi_o,
  output logic              ovf_o,
  output logic              ovf_hi_o
);
  localparam int MID_W  = BYTE_W + PRE_W;
  localparam int WIDE_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] lo_q, hi_q, lo_n, hi_n;
  logic [MID_W-1:0]  pre_sum;
  logic [WIDE_W-1:0] wide_sum;

  always_comb begin
    pre_sum  = {hi_q, lo_q[PRE_W-1:0]} + MID_W'(1);
    wide_sum = {hi_q, lo_q} + WIDE_W'(1);
    lo_n     = lo_q;
    hi_n     = hi_q;
    ovf_o    = 1'b0;
    ovf_hi_o = 1'b0;
    case (mode_i)
      MODE_13B: begin
        if (en_i) begin
          hi_n              = pre_sum[MID_W-1:PRE_W];
          lo_n[PRE_W-1:0]   = pre_sum[PRE_W-1:0];
          ovf_o             = &{hi_q, lo_q[PRE_W-1:0]};
        end
      end
      MODE_16B: begin
        if (en_i) begin
          {hi_n, lo_n} = wide_sum;
          ovf_o        = &{hi_q, lo_q};
        end
      end
      MODE_RELOAD: begin
        if (en_i) begin
          if (&lo_q) begin
            lo_n  = hi_q;
            ovf_o = 1'b1;
          end else begin
            lo_n = lo_q + BYTE_W'(1);
          end
        end
      end
      MODE_SPLIT: begin
        if (SPLIT_OK) begin
          if (en_i) begin
            lo_n  = lo_q + BYTE_W'(1);
            ovf_o = &lo_q;
          end
          if (en_hi_i) begin
            hi_n     = hi_q + BYTE_W'(1);
            ovf_hi_o = &hi_q;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= wr_lo_i ? wdata_i : lo_n;
      hi_q <= wr_hi_i ? wdata_i : hi_n;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int PRE_W       = 5,
  parameter int SLOW_DIV    = 12,
  parameter int FAST_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        fast_sel,
  input  logic [1:0]        div4_sel,
  input  logic [1:0]        count_pin,
  input  logic [1:0]        gate_pin,
  input  logic [2:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic [1:0]        irq_ack,
  output logic [1:0]        ovf_flag
);
  localparam int NT    = 2;
  localparam int CFG_ALL = NT * CFG_W;

  logic [CFG_ALL-1:0]  mode_q;
  logic [NT-1:0]       run_q, flag_q, set_flag;
  logic [NUM_REGS-1:0] wr_hit;
  logic                tick_s, tick_f;
  logic [NT-1:0]       cnt_lvl, cnt_prev, cnt_fall, gate_lvl;
  logic [NT-1:0]       int_tick, cnt_en, unit_ovf, unit_ovf_hi;
  logic                split_en, t0_split;
  tmr_cfg_t            cfg [NT];
  logic [BYTE_W-1:0]   cnt_lo [NT];
  logic [BYTE_W-1:0]   cnt_hi [NT];

  always_comb begin
    for (int a = 0; a < NUM_REGS; a++) begin
      wr_hit[a] = reg_wr && (reg_addr == 3'(a));
    end
  end

  tmr_tick_gen #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_ticks (
    .clk(clk), .rst_n(rst_n), .tick_slow_o(tick_s), .tick_fast_o(tick_f)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_prev <= '0;
    else        cnt_prev <= cnt_lvl;
  end
  assign cnt_fall = cnt_prev & ~cnt_lvl;

  assign t0_split = (cfg[0].mode == MODE_SPLIT);
  assign split_en = run_q[1] & int_tick[0];

  generate
    for (genvar i = 0; i < NT; i++) begin : g_tmr
      assign cfg[i] = tmr_cfg_t'(mode_q[i*CFG_W +: CFG_W]);

      tmr_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(count_pin[i]), .level_o(cnt_lvl[i])
      );
      tmr_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(gate_pin[i]), .level_o(gate_lvl[i])
      );

      assign int_tick[i] = fast_sel[i] | (div4_sel[i] ? tick_f : tick_s);
      assign cnt_en[i]   = run_q[i] & (~cfg[i].gate | gate_lvl[i]) &
                           (cfg[i].ext_sel ? cnt_fall[i] : int_tick[i]);

      tmr_unit #(.BYTE_W(BYTE_W), .PRE_W(PRE_W), .SPLIT_OK(i == 0)) u_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (cfg[i].mode),
        .en_i     (cnt_en[i]),
        .en_hi_i  ((i == 0) ? split_en : 1'b0),
        .wr_lo_i  (wr_hit[2 + 2*i]),
        .wr_hi_i  (wr_hit[3 + 2*i]),
        .wdata_i  (reg_wdata),
        .lo_o     (cnt_lo[i]),
        .hi_o     (cnt_hi[i]),
        .ovf_o    (unit_ovf[i]),
        .ovf_hi_o (unit_ovf_hi[i])
      );
    end
  endgenerate

  assign set_flag[0] = unit_ovf[0];
  assign set_flag[1] = t0_split ? unit_ovf_hi[0] : unit_ovf[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      run_q  <= '0;
      flag_q <= '0;
    end else begin
      if (wr_hit[ADDR_CFG]) mode_q <= reg_wdata[CFG_ALL-1:0];
      for (int i = 0; i < NT; i++) begin
        if (wr_hit[ADDR_CTRL]) run_q[i] <= reg_wdata[2*i];
        if (set_flag[i])           flag_q[i] <= 1'b1;
        else if (irq_ack[i])       flag_q[i] <= 1'b0;
        else if (wr_hit[ADDR_CTRL]) flag_q[i] <= reg_wdata[2*i+1];
      end
    end
  end

  always_comb begin
    case (reg_addr)
      ADDR_CFG:  reg_rdata = BYTE_W'(mode_q);
      ADDR_CTRL: reg_rdata = BYTE_W'({flag_q[1], run_q[1], flag_q[0], run_q[0]});
      ADDR_T0L:  reg_rdata = cnt_lo[0];
      ADDR_T0H:  reg_rdata = cnt_hi[0];
      ADDR_T1L:  reg_rdata = cnt_lo[1];
      ADDR_T1H:  reg_rdata = cnt_hi[1];
      default:   reg_rdata = '0;
    endcase
  end

  assign ovf_flag = flag_q;
endmodule

// File: rtl/tmr_pair_checks.sv
module tmr_pair_checks #(
  parameter int BYTE_W = 8,
  parameter int PRE_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode0,
  input logic [1:0]        mode1,
  input logic              en0,
  input logic [3:0]        wr_cnt,
  input logic [BYTE_W-1:0] t0_lo,
  input logic [BYTE_W-1:0] t0_hi,
  input logic [BYTE_W-1:0] t1_lo,
  input logic [BYTE_W-1:0] t1_hi,
  input logic [1:0]        set_flag,
  input logic [1:0]        flag_q,
  input logic [1:0]        irq_ack
);
  assert_wide_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode0 == 2'd1 && en0 && wr_cnt[1:0] == 2'b00)
      |=> {t0_hi, t0_lo} == $past({t0_hi, t0_lo}) + (2*BYTE_W)'(1));

  assert_prescale_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode0 == 2'd0 && !wr_cnt[0])
      |=> t0_lo[BYTE_W-1:PRE_W] == $past(t0_lo[BYTE_W-1:PRE_W]));

  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode0 == 2'd2 && en0 && (&t0_lo) && !wr_cnt[0])
      |=> t0_lo == $past(t0_hi));

  assert_t1_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode1 == 2'd3 && wr_cnt[3:2] == 2'b00) |=> $stable({t1_hi, t1_lo}));

  assert_ack_clear0_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[0] && irq_ack[0] && !set_flag[0]) |=> !flag_q[0]);

  assert_ack_clear1_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[1] && irq_ack[1] && !set_flag[1]) |=> !flag_q[1]);

  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flag != 2'b00) |=> ((flag_q & $past(set_flag)) == $past(set_flag)));
endmodule

bind tmr_pair tmr_pair_checks #(.BYTE_W(BYTE_W), .PRE_W(PRE_W)) u_checks (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode0    (mode_q[1:0]),
  .mode1    (mode_q[5:4]),
  .en0      (cnt_en[0]),
  .wr_cnt   (wr_hit[5:2]),
  .t0_lo    (cnt_lo[0]),
  .t0_hi    (cnt_hi[0]),
  .t1_lo    (cnt_lo[1]),
  .t1_hi    (cnt_hi[1]),
  .set_flag (set_flag),
  .flag_q   (flag_q),
  .irq_ack  (irq_ack)
);

// File: tb/tmr_pair_test.sv
module tmr_pair_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] fast_sel = '0, div4_sel = '0, count_pin = '0, gate_pin = '0;
  logic [1:0] irq_ack = '0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [1:0] ovf_flag;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  tmr_pair uut (
    .clk(clk), .rst_n(rst_n), .fast_sel(fast_sel), .div4_sel(div4_sel),
    .count_pin(count_pin), .gate_pin(gate_pin), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_ack(irq_ack), .ovf_flag(ovf_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  logic [7:0] m_cfg, m_t0l, m_t0h, m_t1l, m_t1h;
  logic [1:0] m_run, m_flag, m_c1, m_c2, m_cp, m_g1, m_g2;
  int         m_ds, m_df;

  function automatic logic [16:0] step_one(input logic [1:0] md, input logic [7:0] lo_in,
                                           input logic [7:0] hi_in, input logic en);
    logic [12:0] v13;
    logic [15:0] v16;
    logic [7:0]  lo, hi;
    logic        ov;
    lo = lo_in; hi = hi_in; ov = 1'b0;
    if (en) begin
      case (md)
        2'd0: begin
          v13 = {hi, lo[4:0]};
          ov  = (v13 == 13'h1FFF);
          v13 = v13 + 13'd1;
          hi  = v13[12:5];
          lo  = {lo[7:5], v13[4:0]};
        end
        2'd1: begin
          v16 = {hi, lo};
          ov  = (v16 == 16'hFFFF);
          v16 = v16 + 16'd1;
          hi  = v16[15:8];
          lo  = v16[7:0];
        end
        2'd2: begin
          if (lo == 8'hFF) begin lo = hi; ov = 1'b1; end
          else lo = lo + 8'd1;
        end
        default: ;
      endcase
    end
    return {ov, hi, lo};
  endfunction

  function automatic logic [7:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_cfg;
      3'd1: return {4'h0, m_flag[1], m_run[1], m_flag[0], m_run[0]};
      3'd2: return m_t0l;
      3'd3: return m_t0h;
      3'd4: return m_t1l;
      3'd5: return m_t1h;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    logic       ts, tf, enh, ov0, ovh, ov1;
    logic [1:0] it, en, fall, setf;
    logic [16:0] r;
    if (!rst_n) begin
      m_cfg = '0; m_t0l = '0; m_t0h = '0; m_t1l = '0; m_t1h = '0;
      m_run = '0; m_flag = '0; m_c1 = '0; m_c2 = '0; m_cp = '0;
      m_g1 = '0; m_g2 = '0; m_ds = 0; m_df = 0;
    end else begin
      ts = (m_ds == 11);
      tf = (m_df == 3);
      fall = m_cp & ~m_c2;
      for (int i = 0; i < 2; i++) begin
        it[i] = fast_sel[i] | (div4_sel[i] ? tf : ts);
        en[i] = m_run[i] & (~m_cfg[4*i+3] | m_g2[i]) & (m_cfg[4*i+2] ? fall[i] : it[i]);
      end
      enh = m_run[1] & it[0];
      ovh = 1'b0;
      if (m_cfg[1:0] == 2'd3) begin
        ov0 = en[0] && (m_t0l == 8'hFF);
        ovh = enh && (m_t0h == 8'hFF);
        if (en[0]) m_t0l = m_t0l + 8'd1;
        if (enh)   m_t0h = m_t0h + 8'd1;
      end else begin
        r = step_one(m_cfg[1:0], m_t0l, m_t0h, en[0]);
        {ov0, m_t0h, m_t0l} = r;
      end
      if (m_cfg[5:4] == 2'd3) ov1 = 1'b0;
      else begin
        r = step_one(m_cfg[5:4], m_t1l, m_t1h, en[1]);
        {ov1, m_t1h, m_t1l} = r;
      end
      setf[0] = ov0;
      setf[1] = (m_cfg[1:0] == 2'd3) ? ovh : ov1;
      for (int i = 0; i < 2; i++) begin
        if (setf[i])                       m_flag[i] = 1'b1;
        else if (irq_ack[i])               m_flag[i] = 1'b0;
        else if (reg_wr && reg_addr == 3'd1) m_flag[i] = reg_wdata[2*i+1];
        if (reg_wr && reg_addr == 3'd1)     m_run[i] = reg_wdata[2*i];
      end
      if (reg_wr) begin
        case (reg_addr)
          3'd0: m_cfg = reg_wdata;
          3'd2: m_t0l = reg_wdata;
          3'd3: m_t0h = reg_wdata;
          3'd4: m_t1l = reg_wdata;
          3'd5: m_t1h = reg_wdata;
          default: ;
        endcase
      end
      m_cp = m_c2; m_c2 = m_c1; m_c1 = count_pin;
      m_g2 = m_g1; m_g1 = gate_pin;
      m_ds = (m_ds == 11) ? 0 : m_ds + 1;
      m_df = (m_df == 3) ? 0 : m_df + 1;
    end
  end

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(tag, "read", reg_rdata, exp);
  endtask

  // one randomized cycle with model comparison
  task automatic cyc(input string tag, input logic [1:0] runs, input int p_wr, input int p_ack);
    @(negedge clk);
    if ($urandom_range(1, 0) == 1) count_pin = count_pin ^ 2'(1 << $urandom_range(1, 0));
    if ($urandom_range(7, 0) == 0) gate_pin[$urandom_range(1, 0)] ^= 1'b1;
    irq_ack = ($urandom_range(p_ack, 1) == 1) ? 2'($urandom_range(3, 1)) : 2'b00;
    reg_addr = 3'($urandom_range(7, 0));
    reg_wr = 1'b0;
    #1;
    chk(tag, "rdata", reg_rdata, m_read(reg_addr));
    chk(tag, "flags", {6'h0, ovf_flag}, {6'h0, m_flag});
    if ($urandom_range(p_wr, 1) == 1) begin
      reg_addr  = 3'($urandom_range(5, 1));
      reg_wdata = 8'($urandom);
      if (reg_addr == 3'd1) reg_wdata = (reg_wdata & 8'hFA) | {5'h0, runs[1], 1'b0, runs[0]};
      reg_wr = 1'b1;
    end
  endtask

  task automatic phase(input string tag, input logic [7:0] cfgv, input logic [1:0] runs,
                       input logic [1:0] fs, input logic [1:0] d4,
                       input logic [7:0] a_lo, input logic [7:0] a_hi,
                       input logic [7:0] b_lo, input logic [7:0] b_hi,
                       input int ncyc, input int p_wr, input int p_ack);
    wr_reg(3'd1, 8'h00);
    wr_reg(3'd0, cfgv);
    wr_reg(3'd2, a_lo); wr_reg(3'd3, a_hi);
    wr_reg(3'd4, b_lo); wr_reg(3'd5, b_hi);
    @(negedge clk);
    fast_sel = fs; div4_sel = d4;
    wr_reg(3'd1, {5'h0, runs[1], 1'b0, runs[0]});
    for (int k = 0; k < ncyc; k++) cyc(tag, runs, p_wr, p_ack);
    @(negedge clk);
    reg_wr = 1'b0; irq_ack = 2'b00;
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    for (int a = 0; a < 8; a++) rd_chk("R1", 3'(a), 8'h00);
    chk("R1", "flags", {6'h0, ovf_flag}, 8'h00);
    // R2: map and readback
    wr_reg(3'd0, 8'hA5); rd_chk("R2", 3'd0, 8'hA5);
    wr_reg(3'd1, 8'hF0); rd_chk("R2", 3'd1, 8'h00);
    wr_reg(3'd1, 8'h0A); rd_chk("R2", 3'd1, 8'h0A);
    chk("R2", "flags", {6'h0, ovf_flag}, 8'h03);
    wr_reg(3'd3, 8'h5C); rd_chk("R2", 3'd3, 8'h5C);
    wr_reg(3'd4, 8'h3E); rd_chk("R2", 3'd4, 8'h3E);
    rd_chk("R2", 3'd6, 8'h00);
    wr_reg(3'd1, 8'h00);
    // R11: acknowledge and write clear, overflow wins
    wr_reg(3'd1, 8'h0A);
    @(negedge clk); irq_ack = 2'b01;
    @(negedge clk); irq_ack = 2'b00;
    chk("R11", "ack clears flag0", {6'h0, ovf_flag}, 8'h02);
    phase("R3",  8'h11, 2'b11, 2'b11, 2'b00, 8'hF0, 8'hFF, 8'hE0, 8'hFF, 2500, 60, 40);
    phase("R4",  8'h00, 2'b11, 2'b11, 2'b00, 8'hE0, 8'hFF, 8'h1F, 8'hFF, 2500, 60, 40);
    phase("R5",  8'h22, 2'b11, 2'b11, 2'b00, 8'hF0, 8'hF0, 8'hFA, 8'hC0, 2500, 60, 40);
    phase("R6",  8'h13, 2'b11, 2'b11, 2'b00, 8'hF0, 8'hF8, 8'hF0, 8'hFF, 2500, 60, 40);
    phase("R7",  8'h31, 2'b11, 2'b11, 2'b00, 8'hF0, 8'hFF, 8'h12, 8'h34, 2500, 60, 40);
    phase("R8",  8'h99, 2'b11, 2'b11, 2'b00, 8'hF0, 8'hFF, 8'hE0, 8'hFF, 2500, 60, 40);
    phase("R9",  8'h55, 2'b11, 2'b00, 2'b00, 8'hF0, 8'hFF, 8'hF8, 8'hFF, 2500, 60, 40);
    phase("R10", 8'h11, 2'b11, 2'b00, 2'b01, 8'hF8, 8'hFF, 8'hFC, 8'hFF, 2500, 60, 40);
    phase("R10", 8'h22, 2'b11, 2'b10, 2'b01, 8'hF8, 8'hF0, 8'hFC, 8'hF0, 2500, 60, 40);
    phase("R11", 8'h22, 2'b11, 2'b11, 2'b00, 8'hFE, 8'hFE, 8'hFF, 8'hFE, 2500, 30, 3);
    phase("R12", 8'h20, 2'b11, 2'b11, 2'b00, 8'h00, 8'h00, 8'h00, 8'h00, 2500, 3, 20);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog all actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule